// File: doc/BRIEF.md
# Flag-Conditioned Relative Branch Unit

This block carries out the two-byte conditional relative jumps of a small 8-bit processor. A one-cycle `start` pulse hands it the address of the opcode byte and a snapshot of the four condition flags. The unit reads two bytes over a byte-wide fetch port: the opcode, then a signed displacement. It decides whether the jump is taken and presents the next program-counter value together with a one-cycle load strobe.

The sixteen supported opcodes are 0x20 to 0x2F. Each even/odd pair tests one condition and its inverse. The conditions are: always, the unsigned compares built from C OR Z and from C, the single-flag tests on Z, V and N, and the signed compares built from N XOR V and from Z OR (N XOR V). A taken and a not-taken jump use the same number of cycles. Any other opcode is reported as illegal and the program counter is not changed.

The fetch port is synchronous. A byte requested in one cycle with `fetch_req` and `fetch_addr` must be driven on `fetch_data` in the following cycle.

Top module: `relbr_unit`

## Requirements
- R1: While reset is applied, and in the cycle after it, `busy`, `done`, `pc_load`, `illegal` and `fetch_req` are all 0.
- R2: In the first cycle after an accepted start, `fetch_req` is 1 with `fetch_addr` equal to the captured opcode address P. In the second cycle, `fetch_req` is 1 with `fetch_addr` equal to P+1, modulo 2^16.
- R3: For a legal opcode, `done` and `pc_load` are 1 together for exactly one cycle, the third cycle after the start was accepted, whether or not the jump is taken. `done` is 0 in the two cycles before.
- R4: When the jump is taken, `pc_out` equals P+2 plus the displacement byte sign-extended to 16 bits, modulo 2^16.
- R5: When the jump is not taken, `pc_out` equals P+2, modulo 2^16.
- R6: Opcode 0x20 is always taken. Opcode 0x21 is never taken but still fetches its displacement byte.
- R7: Single-flag tests: 0x27 is taken if Z=1 and 0x26 if Z=0; 0x2B is taken if N=1 and 0x2A if N=0; 0x29 is taken if V=1 and 0x28 if V=0. The flags input is ordered {N,Z,V,C}, with N in bit 3 and C in bit 0.
- R8: Unsigned tests: 0x22 is taken if (C|Z)=0 and 0x23 if (C|Z)=1; 0x24 is taken if C=0 and 0x25 if C=1.
- R9: Signed tests: 0x2C is taken if (N^V)=0 and 0x2D if (N^V)=1; 0x2E is taken if (Z|(N^V))=0 and 0x2F if (Z|(N^V))=1.
- R10: An opcode whose upper nibble is not 0x2 (including 0x8D) is illegal. For such an opcode, `illegal` and `done` are 1 for one cycle in the second cycle after start, `pc_load` stays 0, and the unit then returns to idle.
- R11: A start pulse while `busy` is 1 is ignored: the running operation is unaffected and the unit is idle in the cycle after `done`.
- R12: The flags and the opcode address are sampled in the start cycle. Changes to `flags_in` or `pc_in` afterwards do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| pc_in | input | 16 | Address of the opcode byte |
| flags_in | input | 4 | Condition flags {N,Z,V,C} |
| fetch_req | output | 1 | Byte read request |
| fetch_addr | output | 16 | Byte read address |
| fetch_data | input | 8 | Read data, valid one cycle after the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final-cycle strobe |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | 16 | Next program-counter value |
| illegal | output | 1 | Opcode outside the supported set |

## Verification
The bench targets the displacement extremes 0x7F and 0x80 and opcode addresses near 0xFFFF. A unit that zero-extends the displacement or mishandles the 16-bit wrap would jump to the wrong place at these points. It sweeps every opcode across all sixteen flag patterns, which catches an inverted pair or a wrong signed/unsigned condition. It changes the flags and address inputs and fires a second start during each operation. A unit that reads its inputs late or restarts while busy would then use the wrong values or the wrong timing. Illegal opcodes next to the legal range (0x1F, 0x30, 0x8D) confirm that a mis-decoding unit does not load the program counter.

// File: rtl/relbr_pkg.sv
package relbr_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPC  = 2'd1,
        ST_OFS  = 2'd2,
        ST_EXE  = 2'd3
    } br_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    // Condition for the even member of each opcode pair; odd opcodes invert it.
    function automatic logic even_cond(input logic [2:0] idx, input ccr_t f);
        logic lt;
        lt = f.n ^ f.v;
        case (idx)
            3'd0:    even_cond = 1'b1;
            3'd1:    even_cond = ~(f.c | f.z);
            3'd2:    even_cond = ~f.c;
            3'd3:    even_cond = ~f.z;
            3'd4:    even_cond = ~f.v;
            3'd5:    even_cond = ~f.n;
            3'd6:    even_cond = ~lt;
            default: even_cond = ~(f.z | lt);
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] sext_disp(input logic [DATA_W-1:0] d);
        sext_disp = {{(ADDR_W-DATA_W){d[DATA_W-1]}}, d};
    endfunction

    function automatic logic is_branch_op(input logic [DATA_W-1:0] op);
        is_branch_op = (op[DATA_W-1:4] == 4'h2);
    endfunction

endpackage

// File: rtl/relbr_cond.sv
module relbr_cond
    import relbr_pkg::*;
(
    input  logic [3:0] sel,
    input  ccr_t       flags,
    output logic       taken
);
    logic base;

    always_comb begin
        base  = even_cond(sel[3:1], flags);
        taken = sel[0] ? ~base : base;
    end

    always_comb begin
        if (sel == 4'h0) a_r6_always_taken: assert (taken);
        if (sel == 4'h1) a_r6_never_taken:  assert (!taken);
    end
endmodule

// File: rtl/relbr_target.sv
module relbr_target
    import relbr_pkg::*;
(
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] disp,
    output logic [ADDR_W-1:0] next_addr,
    output logic [ADDR_W-1:0] jump_addr
);
    localparam logic [ADDR_W-1:0] INSN_LEN = ADDR_W'(2);

    always_comb begin
        next_addr = op_addr + INSN_LEN;
        jump_addr = next_addr + sext_disp(disp);
    end
endmodule

// File: rtl/relbr_seq.sv
module relbr_seq
    import relbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc_in,
    input  ccr_t              flags_in,
    input  logic [DATA_W-1:0] fetch_data,
    output br_state_e         state,
    output logic [ADDR_W-1:0] pc_q,
    output ccr_t              flags_q,
    output logic [3:0]        sel_q,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              bad_op
);
    br_state_e state_d;

    always_comb begin
        bad_op  = (state == ST_OFS) && !is_branch_op(fetch_data);
        state_d = state;
        case (state)
            ST_IDLE: if (start) state_d = ST_OPC;
            ST_OPC:  state_d = ST_OFS;
            ST_OFS:  state_d = bad_op ? ST_IDLE : ST_EXE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pc_q    <= '0;
            flags_q <= '0;
            sel_q   <= '0;
        end else begin
            state <= state_d;
            if (state == ST_IDLE && start) begin
                pc_q    <= pc_in;
                flags_q <= flags_in;
            end
            if (state == ST_OFS) sel_q <= fetch_data[3:0];
        end
    end

    always_comb begin
        fetch_req  = (state == ST_OPC) || (state == ST_OFS);
        fetch_addr = (state == ST_OFS) ? pc_q + ADDR_W'(1) : pc_q;
    end

    a_r2_offset_follows_opcode: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPC) |=> (fetch_req && fetch_addr == $past(fetch_addr) + ADDR_W'(1)));
    a_r11_start_ignored_busy: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start) |=> $stable(pc_q));
    a_r12_flags_held: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(flags_q));
endmodule

// File: rtl/relbr_unit.sv
module relbr_unit
    import relbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [15:0]       pc_in,
    input  logic [3:0]        flags_in,
    output logic              fetch_req,
    output logic [15:0]       fetch_addr,
    input  logic [7:0]        fetch_data,
    output logic              busy,
    output logic              done,
    output logic              pc_load,
    output logic [15:0]       pc_out,
    output logic              illegal
);
    br_state_e         state;
    logic [ADDR_W-1:0] pc_q;
    ccr_t              flags_q;
    logic [3:0]        sel_q;
    logic              bad_op;
    logic              taken;
    logic [ADDR_W-1:0] next_addr;
    logic [ADDR_W-1:0] jump_addr;

    relbr_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .pc_in      (pc_in),
        .flags_in   (ccr_t'(flags_in)),
        .fetch_data (fetch_data),
        .state      (state),
        .pc_q       (pc_q),
        .flags_q    (flags_q),
        .sel_q      (sel_q),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .bad_op     (bad_op)
    );

    relbr_cond u_cond (
        .sel   (sel_q),
        .flags (flags_q),
        .taken (taken)
    );

    relbr_target u_tgt (
        .op_addr   (pc_q),
        .disp      (fetch_data),
        .next_addr (next_addr),
        .jump_addr (jump_addr)
    );

    always_comb begin
        busy    = (state != ST_IDLE);
        illegal = bad_op;
        pc_load = (state == ST_EXE);
        done    = pc_load || bad_op;
        pc_out  = (pc_load && taken) ? jump_addr : (pc_load ? next_addr : pc_q);
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !done && !pc_load && !illegal && !fetch_req));
    a_r3_done_third_cycle: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> ($past(start && !busy, 3) && done));
    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r10_illegal_no_load: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (done && !pc_load));
    a_r10_illegal_to_idle: assert property (@(posedge clk) disable iff (rst)
        illegal |=> !busy);
endmodule

// File: tb/sim_relbr_unit.sv
module sim_relbr_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] pc_in;
    logic [3:0]  flags_in;
    logic        fetch_req;
    logic [15:0] fetch_addr;
    logic [7:0]  fetch_data;
    logic        busy, done, pc_load, illegal;
    logic [15:0] pc_out;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] mem_pc, mem_pc1;
    logic [7:0]  mem_op, mem_off;

    always #2 clk = ~clk;

    relbr_unit u0 (
        .clk(clk), .rst(rst), .start(start), .pc_in(pc_in), .flags_in(flags_in),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .busy(busy), .done(done), .pc_load(pc_load), .pc_out(pc_out), .illegal(illegal)
    );

    always @(posedge clk) begin
        if (fetch_req)
            fetch_data <= (fetch_addr == mem_pc)  ? mem_op :
                          (fetch_addr == mem_pc1) ? mem_off : 8'h00;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit ref_taken(input logic [7:0] op, input logic [3:0] f);
        logic n, z, v, c;
        {n, z, v, c} = f;
        case (op)
            8'h20: return 1'b1;
            8'h21: return 1'b0;
            8'h22: return (c | z) == 1'b0;
            8'h23: return (c | z) == 1'b1;
            8'h24: return c == 1'b0;
            8'h25: return c == 1'b1;
            8'h26: return z == 1'b0;
            8'h27: return z == 1'b1;
            8'h28: return v == 1'b0;
            8'h29: return v == 1'b1;
            8'h2A: return n == 1'b0;
            8'h2B: return n == 1'b1;
            8'h2C: return (n ^ v) == 1'b0;
            8'h2D: return (n ^ v) == 1'b1;
            8'h2E: return (z | (n ^ v)) == 1'b0;
            default: return (z | (n ^ v)) == 1'b1;
        endcase
    endfunction

    function automatic string op_tag(input logic [7:0] op);
        if (op == 8'h20 || op == 8'h21) return "R6";
        if (op >= 8'h22 && op <= 8'h25) return "R8";
        if (op >= 8'h2C) return "R9";
        return "R7";
    endfunction

    task automatic run(input logic [15:0] pc, input logic [7:0] op, input logic [7:0] off, input logic [3:0] fl);
        logic [15:0] nxt, tgt, exp;
        bit tk;
        mem_pc = pc; mem_pc1 = pc + 16'd1; mem_op = op; mem_off = off;
        nxt = pc + 16'd2;
        tgt = nxt + {{8{off[7]}}, off};
        @(negedge clk); start = 1'b1; pc_in = pc; flags_in = fl;
        @(negedge clk); start = 1'b0; flags_in = ~fl; pc_in = 16'($urandom);
        check(fetch_req && fetch_addr == pc && !done, "R2 opcode fetch", {15'd0, fetch_req, fetch_addr}, {16'd1, pc});
        start = 1'b1;   // ignored while busy (R11)
        @(negedge clk); start = 1'b0;
        if (op[7:4] != 4'h2) begin
            check(illegal && done && !pc_load, "R10 illegal opcode",
                  {29'd0, illegal, done, pc_load}, 32'h6);
            @(negedge clk);
            check(!busy && !done, "R11 idle after illegal", {30'd0, busy, done}, 32'h0);
            return;
        end
        check(fetch_req && fetch_addr == mem_pc1 && !done, "R2 offset fetch", {15'd0, fetch_req, fetch_addr}, {16'd1, mem_pc1});
        @(negedge clk);
        tk  = ref_taken(op, fl);
        exp = tk ? tgt : nxt;
        check(done && pc_load && !illegal, "R3 done timing", {29'd0, done, pc_load, illegal}, 32'h6);
        check(pc_out == exp, $sformatf("%s %s R12 op=%h fl=%h", op_tag(op), tk ? "R4" : "R5", op, fl), {16'd0, pc_out}, {16'd0, exp});
        @(negedge clk);
        check(!busy && !done && !pc_load, "R11 idle after done", {29'd0, busy, done, pc_load}, 32'h0);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; start = 1'b0; pc_in = '0; flags_in = '0;
        mem_pc = '0; mem_pc1 = 16'd1; mem_op = '0; mem_off = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !pc_load && !illegal && !fetch_req, "R1 reset state",
              {27'd0, busy, done, pc_load, illegal, fetch_req}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !fetch_req, "R1 after reset", {29'd0, busy, done, fetch_req}, 32'h0);

        // Every opcode against every flag pattern (R6..R9)
        for (int o = 8'h20; o <= 8'h2F; o++)
            for (int f = 0; f < 16; f++)
                run(16'h1000 + 16'(o * 16), 8'(o), 8'h10, 4'(f));

        // Displacement extremes and address wrap (R4, R5)
        run(16'h4000, 8'h20, 8'h7F, 4'h0);
        run(16'h4000, 8'h20, 8'h80, 4'h0);
        run(16'hFFFE, 8'h20, 8'h05, 4'h0);
        run(16'hFFFF, 8'h20, 8'hFE, 4'h0);
        run(16'h0000, 8'h20, 8'hF0, 4'h0);
        run(16'hFFFF, 8'h21, 8'h33, 4'hF);

        // Illegal opcodes (R10)
        run(16'h2000, 8'h1F, 8'h00, 4'h0);
        run(16'h2000, 8'h30, 8'h00, 4'h0);
        run(16'h2000, 8'h8D, 8'h00, 4'h0);
        run(16'h2000, 8'h00, 8'h00, 4'hF);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            op = ($urandom % 8 == 0) ? 8'($urandom) : {4'h2, 4'($urandom)};
            run(16'($urandom), op, 8'($urandom), 4'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule